// File: doc/BRIEF.md
# Retirement trace packet serializer

This block turns one retired-instruction record into a byte-serial trace packet of variable length. A record carries the instruction's sequence number, its instruction word, the trap, halt and interrupt markers, the privilege mode and integer width, the program counter before and after execution, optional integer register results and an optional memory access. Each accepted record becomes a packet. The packet starts with a fixed 448-bit header holding a version word, a size word, a metadata section, a PC section and a word of availability flags. An integer section and a memory section of 256 bits each follow the header, and each one is appended only when the record marks it as used.

The packet leaves the block least significant byte first on an 8-bit valid/ready stream, with a marker on the final byte. The record input is ready only while no packet is being sent. A separate capability request makes the block send a fixed 704-bit packet in the older single-block layout. That packet is all zero except its halt byte, which reads 0x03 to announce that the sectioned layout is supported.

Top module: `trace_pkt_ser`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Header bits 31:0 hold the value 2 and bits 63:32 hold the packet size in bits. The metadata section (bits 255:64) holds order in 63:0, insn in 127:64, trap in 135:128, halt in 143:136, intr in 151:144, mode in 159:152 and ixl in 167:160, a valid byte equal to 1 in 175:168, and zeros in 191:176. Packet bit k travels in output byte k/8, at bit position k%8.
- R3: Header bits 319:256 hold pc_cur and bits 383:320 hold pc_next.
- R4: When int_used is 1, flag bit 384 is 1 and a 256-bit section follows the header. It holds rd_wdata in 63:0, rs1_rdata in 127:64, rs2_rdata in 191:128, rd_addr in 199:192, rs1_addr in 207:200, rs2_addr in 215:208 and zeros above. When int_used is 0, the flag is 0 and the section is not sent.
- R5: When mem_used is 1, flag bit 385 is 1 and a 256-bit section follows directly after the integer section, or directly after the header if there is no integer section. It holds mem_addr in 63:0, mem_rdata in 127:64, mem_wdata in 191:128, the read mask in 223:192 and the write mask in 255:224. Flag bits 447:386 are always 0.
- R6: The size field equals 448, plus 256 if the integer section is present, plus 256 if the memory section is present. Exactly size/8 bytes are sent: 56, 88 or 120.
- R7: A byte count N of 0 to 32 on mem_rbytes or mem_wbytes gives a 32-bit mask with its low N bits set. A count above 32 gives an all-ones mask.
- R8: A capability request sends 88 bytes that are all zero except byte 86, which is 0x03 (bits 695:688). While cap_req is high, in_ready is 0 and no record is taken.
- R9: While out_valid is 1 and out_ready is 0, out_data and out_last hold their values in the next cycle.
- R10: in_ready is 0 while a packet is being sent. The cycle after the last byte is taken, out_valid is 0 and in_ready is 1.
- R11: out_last is 1 on the final byte of each packet and on no other byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_valid | input | 1 | Retirement record present |
| in_ready | output | 1 | Block idle, so a record or request can be taken |
| cap_req | input | 1 | Capability query request |
| rec_order | input | 64 | Instruction sequence number |
| rec_insn | input | 64 | Instruction word |
| rec_trap | input | 8 | Trap marker |
| rec_halt | input | 8 | Halt marker |
| rec_intr | input | 8 | First instruction of a handler |
| rec_mode | input | 8 | Privilege mode |
| rec_ixl | input | 8 | Integer register width code |
| pc_cur | input | 64 | PC of the retired instruction |
| pc_next | input | 64 | PC of the next instruction |
| int_used | input | 1 | Register write recorded |
| rd_wdata | input | 64 | Destination value after execution |
| rs1_rdata | input | 64 | First source value |
| rs2_rdata | input | 64 | Second source value |
| rd_addr | input | 8 | Destination register index |
| rs1_addr | input | 8 | First source register index |
| rs2_addr | input | 8 | Second source register index |
| mem_used | input | 1 | Memory access recorded |
| mem_addr | input | 64 | Accessed address |
| mem_rdata | input | 64 | Data read |
| mem_wdata | input | 64 | Data written |
| mem_rbytes | input | 6 | Bytes read |
| mem_wbytes | input | 6 | Bytes written |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts a byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of a packet |

## Verification
A record or request accepted at a clock edge makes its first byte visible on the output one cycle later, because the packet is loaded straight into the output shift register. Each later byte appears one cycle after the previous byte is taken. The cycle after the final byte is taken, out_valid falls and in_ready rises. The bench drives inputs and samples outputs at the falling edge. It logs a byte only when out_valid and its own out_ready are both high at that point, so each logged byte is the one taken at the next rising edge. The logged bytes are then compared with a packet built in the bench from the record fields, together with the byte count and the position of the last marker.

// File: rtl/trace_pkt_pkg.sv
package trace_pkt_pkg;
  localparam int HDR_BITS    = 448;
  localparam int EXT_BITS    = 256;
  localparam int MAX_BITS    = HDR_BITS + 2 * EXT_BITS;
  localparam int LEGACY_BITS = 704;
  localparam int LEG_HALT_LO = 688;
  localparam int MASK_W      = 32;
  localparam logic [31:0] FMT_VERSION = 32'd2;
  localparam logic [7:0]  CAP_HALT    = 8'h03;
endpackage

// File: rtl/trace_pkt_mask.sv
module trace_pkt_mask #(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1) + 1
) (
  input  logic [CW-1:0] nbytes,
  output logic [W-1:0]  mask
);
  always_comb begin
    if (nbytes == '0)
      mask = '0;
    else if (int'(nbytes) >= W)
      mask = '1;
    else
      mask = {W{1'b1}} >> (W - int'(nbytes));
  end
endmodule

// File: rtl/trace_pkt_fmt.sv
module trace_pkt_fmt
  import trace_pkt_pkg::*;
#(
  parameter int OUT_W = 8,
  localparam int LEN_W = $clog2(MAX_BITS / OUT_W + 1)
) (
  input  logic                 legacy,
  input  logic [63:0]          rec_order,
  input  logic [63:0]          rec_insn,
  input  logic [7:0]           rec_trap,
  input  logic [7:0]           rec_halt,
  input  logic [7:0]           rec_intr,
  input  logic [7:0]           rec_mode,
  input  logic [7:0]           rec_ixl,
  input  logic [63:0]          pc_cur,
  input  logic [63:0]          pc_next,
  input  logic                 int_used,
  input  logic [63:0]          rd_wdata,
  input  logic [63:0]          rs1_rdata,
  input  logic [63:0]          rs2_rdata,
  input  logic [7:0]           rd_addr,
  input  logic [7:0]           rs1_addr,
  input  logic [7:0]           rs2_addr,
  input  logic                 mem_used,
  input  logic [63:0]          mem_addr,
  input  logic [63:0]          mem_rdata,
  input  logic [63:0]          mem_wdata,
  input  logic [5:0]           mem_rbytes,
  input  logic [5:0]           mem_wbytes,
  output logic [MAX_BITS-1:0]  pkt,
  output logic [LEN_W-1:0]     pkt_len
);
  logic [MASK_W-1:0] rmask, wmask;
  logic [191:0]      meta;
  logic [127:0]      pcs;
  logic [63:0]       flags;
  logic [31:0]       size_bits;
  logic [HDR_BITS-1:0] hdr;
  logic [EXT_BITS-1:0] int_sec, mem_sec;

  trace_pkt_mask #(.W(MASK_W)) u_rmask (.nbytes({1'b0, mem_rbytes}), .mask(rmask));
  trace_pkt_mask #(.W(MASK_W)) u_wmask (.nbytes({1'b0, mem_wbytes}), .mask(wmask));

  always_comb begin
    meta      = {16'h0, 8'h01, rec_ixl, rec_mode, rec_intr, rec_halt, rec_trap,
                 rec_insn, rec_order};
    pcs       = {pc_next, pc_cur};
    flags     = {62'h0, mem_used, int_used};
    size_bits = 32'(HDR_BITS) + (int_used ? 32'(EXT_BITS) : 32'd0)
                              + (mem_used ? 32'(EXT_BITS) : 32'd0);
    hdr       = {flags, pcs, meta, size_bits, FMT_VERSION};
    int_sec   = {40'h0, rs2_addr, rs1_addr, rd_addr, rs2_rdata, rs1_rdata, rd_wdata};
    mem_sec   = {wmask, rmask, mem_wdata, mem_rdata, mem_addr};

    pkt = '0;
    if (legacy) begin
      pkt[LEG_HALT_LO +: 8] = CAP_HALT;
      pkt_len = LEN_W'(LEGACY_BITS / OUT_W);
    end else begin
      pkt[HDR_BITS-1:0] = hdr;
      if (int_used) pkt[HDR_BITS +: EXT_BITS] = int_sec;
      if (mem_used) begin
        if (int_used) pkt[HDR_BITS + EXT_BITS +: EXT_BITS] = mem_sec;
        else          pkt[HDR_BITS +: EXT_BITS]            = mem_sec;
      end
      pkt_len = LEN_W'(size_bits / OUT_W);
    end
  end
endmodule

// File: rtl/trace_pkt_shifter.sv
module trace_pkt_shifter #(
  parameter int BITS  = 960,
  parameter int OUT_W = 8,
  localparam int LEN_W = $clog2(BITS / OUT_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [BITS-1:0]  load_data,
  input  logic [LEN_W-1:0] load_len,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  output logic             out_last,
  output logic             idle
);
  logic [BITS-1:0]  sreg;
  logic [LEN_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg   <= '0;
      remain <= '0;
    end else if (load && remain == '0) begin
      sreg   <= load_data;
      remain <= load_len;
    end else if (remain != '0 && out_ready) begin
      sreg   <= sreg >> OUT_W;
      remain <= remain - 1'b1;
    end
  end

  assign out_valid = (remain != '0);
  assign out_data  = sreg[OUT_W-1:0];
  assign out_last  = (remain == LEN_W'(1));
  assign idle      = (remain == '0);
endmodule

// File: rtl/trace_pkt_ser.sv
module trace_pkt_ser
  import trace_pkt_pkg::*;
#(
  parameter int OUT_W = 8,
  localparam int LEN_W = $clog2(MAX_BITS / OUT_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rec_valid,
  output logic             in_ready,
  input  logic             cap_req,
  input  logic [63:0]      rec_order,
  input  logic [63:0]      rec_insn,
  input  logic [7:0]       rec_trap,
  input  logic [7:0]       rec_halt,
  input  logic [7:0]       rec_intr,
  input  logic [7:0]       rec_mode,
  input  logic [7:0]       rec_ixl,
  input  logic [63:0]      pc_cur,
  input  logic [63:0]      pc_next,
  input  logic             int_used,
  input  logic [63:0]      rd_wdata,
  input  logic [63:0]      rs1_rdata,
  input  logic [63:0]      rs2_rdata,
  input  logic [7:0]       rd_addr,
  input  logic [7:0]       rs1_addr,
  input  logic [7:0]       rs2_addr,
  input  logic             mem_used,
  input  logic [63:0]      mem_addr,
  input  logic [63:0]      mem_rdata,
  input  logic [63:0]      mem_wdata,
  input  logic [5:0]       mem_rbytes,
  input  logic [5:0]       mem_wbytes,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data,
  output logic             out_last
);
  logic [MAX_BITS-1:0] pkt;
  logic [LEN_W-1:0]    pkt_len;
  logic                idle;
  logic                start;

  assign in_ready = idle && !cap_req;
  assign start    = idle && (cap_req || rec_valid);

  trace_pkt_fmt #(.OUT_W(OUT_W)) u_fmt (
    .legacy(cap_req), .rec_order(rec_order), .rec_insn(rec_insn),
    .rec_trap(rec_trap), .rec_halt(rec_halt), .rec_intr(rec_intr),
    .rec_mode(rec_mode), .rec_ixl(rec_ixl), .pc_cur(pc_cur), .pc_next(pc_next),
    .int_used(int_used), .rd_wdata(rd_wdata), .rs1_rdata(rs1_rdata),
    .rs2_rdata(rs2_rdata), .rd_addr(rd_addr), .rs1_addr(rs1_addr),
    .rs2_addr(rs2_addr), .mem_used(mem_used), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_rbytes(mem_rbytes),
    .mem_wbytes(mem_wbytes), .pkt(pkt), .pkt_len(pkt_len)
  );

  trace_pkt_shifter #(.BITS(MAX_BITS), .OUT_W(OUT_W)) u_shift (
    .clk(clk), .rst(rst), .load(start), .load_data(pkt), .load_len(pkt_len),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .idle(idle)
  );
endmodule

// File: rtl/trace_pkt_ser_chk.sv
module trace_pkt_ser_chk #(
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             rec_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data,
  input logic             out_last
);
  assert_busy_blocks_input_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_last_only_valid_R11: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  assert_idle_after_last_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> !out_valid);

  assert_first_byte_version_R2: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && in_ready) |=> (out_valid && out_data == OUT_W'(2)));
endmodule

bind trace_pkt_ser trace_pkt_ser_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .rec_valid(rec_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_last(out_last)
);

// File: tb/trace_pkt_ser_tb.sv
module trace_pkt_ser_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB = 960;

  logic clk = 1'b0, rst = 1'b1;
  logic rec_valid = 0, cap_req = 0, out_ready = 0;
  logic in_ready, out_valid, out_last;
  logic [7:0] out_data;
  logic [63:0] r_order, r_insn, r_pcc, r_pcn, r_rdw, r_rs1, r_rs2, r_ma, r_mr, r_mw;
  logic [7:0]  r_trap, r_halt, r_intr, r_mode, r_ixl, r_rda, r_rs1a, r_rs2a;
  logic        r_int, r_mem;
  logic [5:0]  r_rb, r_wb;
  int tests = 0, fails = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_pkt_ser u_dut (
    .clk(clk), .rst(rst), .rec_valid(rec_valid), .in_ready(in_ready), .cap_req(cap_req),
    .rec_order(r_order), .rec_insn(r_insn), .rec_trap(r_trap), .rec_halt(r_halt),
    .rec_intr(r_intr), .rec_mode(r_mode), .rec_ixl(r_ixl), .pc_cur(r_pcc),
    .pc_next(r_pcn), .int_used(r_int), .rd_wdata(r_rdw), .rs1_rdata(r_rs1),
    .rs2_rdata(r_rs2), .rd_addr(r_rda), .rs1_addr(r_rs1a), .rs2_addr(r_rs2a),
    .mem_used(r_mem), .mem_addr(r_ma), .mem_rdata(r_mr), .mem_wdata(r_mw),
    .mem_rbytes(r_rb), .mem_wbytes(r_wb), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, got %0d cycles expected < 150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_mask(input int n);
    logic [31:0] m = '0;
    for (int i = 0; i < 32; i++) if (i < n) m[i] = 1'b1;
    return m;
  endfunction

  function automatic int exp_build(input bit legacy, output logic [MAXB-1:0] v);
    int off;
    v = '0;
    if (legacy) begin v[695:688] = 8'h03; return 88; end
    v[31:0]    = 32'd2;
    v[63:32]   = 448 + (r_int ? 256 : 0) + (r_mem ? 256 : 0);
    v[127:64]  = r_order;  v[191:128] = r_insn;
    v[199:192] = r_trap;   v[207:200] = r_halt;  v[215:208] = r_intr;
    v[223:216] = r_mode;   v[231:224] = r_ixl;   v[239:232] = 8'h01;
    v[319:256] = r_pcc;    v[383:320] = r_pcn;
    v[384] = r_int; v[385] = r_mem;
    off = 448;
    if (r_int) begin
      v[off +: 64] = r_rdw; v[off+64 +: 64] = r_rs1; v[off+128 +: 64] = r_rs2;
      v[off+192 +: 8] = r_rda; v[off+200 +: 8] = r_rs1a; v[off+208 +: 8] = r_rs2a;
      off += 256;
    end
    if (r_mem) begin
      v[off +: 64] = r_ma; v[off+64 +: 64] = r_mr; v[off+128 +: 64] = r_mw;
      v[off+192 +: 32] = mk_mask(int'(r_rb)); v[off+224 +: 32] = mk_mask(int'(r_wb));
      off += 256;
    end
    return off / 8;
  endfunction

  task automatic rand_rec(input bit i_used, input bit m_used);
    r_order = {$urandom, $urandom}; r_insn = {32'h0, $urandom};
    r_trap = 8'($urandom % 2); r_halt = 8'($urandom % 2); r_intr = 8'($urandom % 2);
    r_mode = 8'($urandom % 4); r_ixl = 8'(1 + $urandom % 2);
    r_pcc = {$urandom, $urandom}; r_pcn = {$urandom, $urandom};
    r_int = i_used; r_rdw = {$urandom, $urandom}; r_rs1 = {$urandom, $urandom};
    r_rs2 = {$urandom, $urandom}; r_rda = 8'($urandom % 32); r_rs1a = 8'($urandom % 32);
    r_rs2a = 8'($urandom % 32); r_mem = m_used; r_ma = {$urandom, $urandom};
    r_mr = {$urandom, $urandom}; r_mw = {$urandom, $urandom};
    r_rb = 6'($urandom % 33); r_wb = 6'($urandom % 33);
  endtask

  // Drive one record (or query) and collect its packet; stall_pct is the chance of out_ready low.
  task automatic run_pkt(input bit legacy, input bit both, input int stall_pct, input string req);
    logic [MAXB-1:0] exp_v, got_v;
    int exp_n, n, bad_last, bad_busy;
    bit done;
    exp_n = exp_build(legacy, exp_v);
    got_v = '0; n = 0; bad_last = 0; bad_busy = 0; done = 0;
    @(negedge clk);
    if (legacy) begin
      cap_req = 1; rec_valid = both; #1;
      chk(in_ready == 1'b0, "R8", "in_ready during query", in_ready, 0);
    end else begin
      rec_valid = 1; #1;
      chk(in_ready == 1'b1, "R10", "in_ready when idle", in_ready, 1);
    end
    @(negedge clk);
    cap_req = 0; rec_valid = 0;
    while (!done) begin
      out_ready = (($urandom % 100) >= stall_pct);
      #1;
      if (out_valid && in_ready) bad_busy++;
      if (out_valid && out_ready) begin
        got_v[n*8 +: 8] = out_data;
        if (out_last != (n == exp_n - 1)) bad_last++;
        n++;
        if (out_last || n >= 130) done = 1;
      end
      @(negedge clk);
    end
    out_ready = 0; #1;
    chk(n == exp_n, "R6", "byte count", n, exp_n);
    chk(got_v == exp_v, req, "packet content", got_v[63:0] ^ exp_v[63:0], 0);
    chk(bad_last == 0, "R11", "last marker misplaced", bad_last, 0);
    chk(bad_busy == 0, "R10", "in_ready high while busy", bad_busy, 0);
    chk(!out_valid && in_ready, "R10", "idle after last", {out_valid, in_ready}, 2'b01);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rand_rec(0, 0);
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    chk(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);

    rand_rec(0, 0); run_pkt(0, 0, 0,  "R2");   // header only, no stall
    rand_rec(0, 0); run_pkt(0, 0, 0,  "R3");
    rand_rec(1, 0); run_pkt(0, 0, 30, "R4");   // integer section only
    rand_rec(0, 1); run_pkt(0, 0, 30, "R5");   // memory directly after header
    rand_rec(1, 1); run_pkt(0, 0, 50, "R5");   // both sections
    rand_rec(0, 1); r_rb = 0;  r_wb = 32; run_pkt(0, 0, 10, "R7");
    rand_rec(0, 1); r_rb = 1;  r_wb = 8;  run_pkt(0, 0, 10, "R7");
    rand_rec(0, 1); r_rb = 63; r_wb = 33; run_pkt(0, 0, 10, "R7");
    run_pkt(1, 0, 20, "R8");                   // capability query
    rand_rec(1, 1); run_pkt(1, 1, 20, "R8");   // query wins over a record
    rand_rec(1, 1); run_pkt(0, 0, 80, "R9");   // heavy backpressure
    for (int k = 0; k < 40; k++) begin
      rand_rec($urandom % 2, $urandom % 2);
      run_pkt(0, 0, $urandom % 60, "R6");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule